// File: doc/BRIEF.md
# Thirty-Two Pin Register-Mapped GPIO Controller

This block is a general-purpose I/O controller for a bank of 32 pads. A processor reaches it through a simple 32-bit bus with an address, write data, a write strobe, a read strobe and a registered read-data return. Software sets the output level, the drive enable and the open-drain mode of each pin. It reads the synchronized pad levels back through an input word.

Each pin has two 2-bit source codes. One picks where the pad's data comes from and the other picks where its drive enable comes from. The choices are the controller's own registers or one of three alternate-function vectors that arrive at the block boundary. Open-drain mode turns the selected data and enable into a pull-low-or-release drive.

Pin numbering runs from the most significant bit down: pin 0 is bit 31.

Top module: `gpio32_ctrl`

## Requirements
- R1: Pin n (0..31) corresponds to bit 31-n of busWData, busRData, padOut, padOe, padIn and of the alternate vectors.
- R2: Word offsets are 0x00 output value, 0x04 drive enable, 0x08 data-source codes for pins 0-15, 0x0C data-source codes for pins 16-31, 0x10 enable-source codes for pins 0-15, 0x14 enable-source codes for pins 16-31, 0x18 open-drain enable and 0x1C input (read-only). A write takes effect at the rising edge where busWe is high. busRData is loaded at the rising edge where busRe is high and holds its value at every other edge.
- R3: After reset, every writable register reads 0 and padOut and padOe are all 0.
- R4: With source code 00 and open-drain off, a drive-enable bit of 1 sets the pin's padOe and a bit of 0 clears it. padOut follows the output-value bit.
- R5: The 2-bit code of pin n occupies bits [31-2n:30-2n] of the low register for n<16. For n>=16 it occupies bits [31-2(n-16):30-2(n-16)] of the high register.
- R6: Data-source code 00 takes the output-value bit. Codes 01, 10 and 11 take the pin's bit of altOut1, altOut2 and altOut3.
- R7: Enable-source code 00 takes the drive-enable bit. Codes 01, 10 and 11 take the pin's bit of altOe1, altOe2 and altOe3.
- R8: When a pin's open-drain bit is 1, its padOut is 0 and its padOe equals the selected enable AND NOT the selected data.
- R9: padIn passes through two synchronizer flops and then the input register. A level applied before rising edge 1 is visible to a read strobed at edge 4 and not to one strobed at edge 3.
- R10: Writes to 0x1C and to any offset from 0x20 upward change no register. Every offset from 0x20 upward reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 7 | Byte address, word aligned |
| busWData | input | 32 | Write data |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe |
| busRData | output | 32 | Registered read data |
| altOut1 | input | 32 | Alternate data, source code 01 |
| altOut2 | input | 32 | Alternate data, source code 10 |
| altOut3 | input | 32 | Alternate data, source code 11 |
| altOe1 | input | 32 | Alternate enable, source code 01 |
| altOe2 | input | 32 | Alternate enable, source code 10 |
| altOe3 | input | 32 | Alternate enable, source code 11 |
| padOut | output | 32 | Pad data |
| padOe | output | 32 | Pad drive enable |
| padIn | input | 32 | Raw pad levels |

## Verification
The source code and the open-drain mode act on the same pad in the same cycle. The bench therefore sets both on one pin together with mixed data and enable patterns. It judges padOut and padOe against the pull-low-or-release rule applied to the selected source, not to the register bits.

The bench sweeps every pin with every source code. For each step it compares the whole padOut and padOe vectors with an expected word computed from the field arithmetic, so a field at the wrong position shows up on the pin that actually moved.

// File: rtl/gpio32_pkg.sv
package gpio32_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 7;

  typedef enum logic [3:0] {
    SEL_OUT, SEL_TRI, SEL_OSELL, SEL_OSELH,
    SEL_TSELL, SEL_TSELH, SEL_OD, SEL_IN, SEL_ZERO
  } regSel_e;

  typedef struct packed {
    logic    wrOut;
    logic    wrTri;
    logic    wrOselL;
    logic    wrOselH;
    logic    wrTselL;
    logic    wrTselH;
    logic    wrOd;
    logic    rdEn;
    regSel_e rdSel;
  } gpioStrobe_t;
endpackage

// File: rtl/gpio32_regctl.sv
module gpio32_regctl
  import gpio32_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] busAddr,
  input  logic          busWe,
  input  logic          busRe,
  output gpioStrobe_t   ctl
);
  localparam int IDX_W = AW - 2;
  logic [IDX_W-1:0] wordIdx;
  assign wordIdx = busAddr[AW-1:2];

  always_comb begin
    ctl = '0;
    ctl.rdEn = busRe;
    unique case (wordIdx)
      IDX_W'(0): begin ctl.wrOut   = busWe; ctl.rdSel = SEL_OUT;   end
      IDX_W'(1): begin ctl.wrTri   = busWe; ctl.rdSel = SEL_TRI;   end
      IDX_W'(2): begin ctl.wrOselL = busWe; ctl.rdSel = SEL_OSELL; end
      IDX_W'(3): begin ctl.wrOselH = busWe; ctl.rdSel = SEL_OSELH; end
      IDX_W'(4): begin ctl.wrTselL = busWe; ctl.rdSel = SEL_TSELL; end
      IDX_W'(5): begin ctl.wrTselH = busWe; ctl.rdSel = SEL_TSELH; end
      IDX_W'(6): begin ctl.wrOd    = busWe; ctl.rdSel = SEL_OD;    end
      IDX_W'(7): ctl.rdSel = SEL_IN;
      default:   ctl.rdSel = SEL_ZERO;
    endcase
  end

  // R10: at most one register is written per cycle, and only under busWe
  p_one_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.wrOut, ctl.wrTri, ctl.wrOselL, ctl.wrOselH,
              ctl.wrTselL, ctl.wrTselH, ctl.wrOd}));
  p_no_write_high_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wordIdx >= IDX_W'(7)) |-> !(ctl.wrOut | ctl.wrTri | ctl.wrOd));
endmodule

// File: rtl/gpio32_datapath.sv
module gpio32_datapath
  import gpio32_pkg::*;
#(
  parameter int PINS        = DATA_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  gpioStrobe_t     ctl,
  input  logic [PINS-1:0] busWData,
  output logic [PINS-1:0] busRData,
  input  logic [PINS-1:0] altOut1,
  input  logic [PINS-1:0] altOut2,
  input  logic [PINS-1:0] altOut3,
  input  logic [PINS-1:0] altOe1,
  input  logic [PINS-1:0] altOe2,
  input  logic [PINS-1:0] altOe3,
  output logic [PINS-1:0] padOut,
  output logic [PINS-1:0] padOe,
  input  logic [PINS-1:0] padIn
);
  localparam int HALF = PINS / 2;

  logic [PINS-1:0] outReg, triReg, oselL, oselH, tselL, tselH, odReg, inReg;
  logic [PINS-1:0] syncPipe [SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outReg <= '0; triReg <= '0; oselL <= '0; oselH <= '0;
      tselL  <= '0; tselH  <= '0; odReg <= '0;
    end else begin
      if (ctl.wrOut)   outReg <= busWData;
      if (ctl.wrTri)   triReg <= busWData;
      if (ctl.wrOselL) oselL  <= busWData;
      if (ctl.wrOselH) oselH  <= busWData;
      if (ctl.wrTselL) tselL  <= busWData;
      if (ctl.wrTselH) tselH  <= busWData;
      if (ctl.wrOd)    odReg  <= busWData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncPipe[s] <= '0;
      inReg <= '0;
    end else begin
      syncPipe[0] <= padIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncPipe[s] <= syncPipe[s-1];
      inReg <= syncPipe[SYNC_STAGES-1];
    end
  end

  logic [PINS-1:0] rdMux;
  always_comb begin
    unique case (ctl.rdSel)
      SEL_OUT:   rdMux = outReg;
      SEL_TRI:   rdMux = triReg;
      SEL_OSELL: rdMux = oselL;
      SEL_OSELH: rdMux = oselH;
      SEL_TSELL: rdMux = tselL;
      SEL_TSELH: rdMux = tselH;
      SEL_OD:    rdMux = odReg;
      SEL_IN:    rdMux = inReg;
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)         busRData <= '0;
    else if (ctl.rdEn) busRData <= rdMux;
  end

  for (genvar n = 0; n < PINS; n++) begin : g_pin
    localparam int BIT  = PINS - 1 - n;
    localparam int FPOS = (PINS - 2) - 2 * (n % HALF);
    logic [1:0] oCode, tCode;
    logic srcOut, srcOe;
    if (n < HALF) begin : g_lo
      assign oCode = oselL[FPOS +: 2];
      assign tCode = tselL[FPOS +: 2];
    end else begin : g_hi
      assign oCode = oselH[FPOS +: 2];
      assign tCode = tselH[FPOS +: 2];
    end
    always_comb begin
      unique case (oCode)
        2'b00: srcOut = outReg[BIT];
        2'b01: srcOut = altOut1[BIT];
        2'b10: srcOut = altOut2[BIT];
        default: srcOut = altOut3[BIT];
      endcase
      unique case (tCode)
        2'b00: srcOe = triReg[BIT];
        2'b01: srcOe = altOe1[BIT];
        2'b10: srcOe = altOe2[BIT];
        default: srcOe = altOe3[BIT];
      endcase
    end
    assign padOut[BIT] = odReg[BIT] ? 1'b0 : srcOut;
    assign padOe[BIT]  = odReg[BIT] ? (srcOe & ~srcOut) : srcOe;
  end

  p_out_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrOut |=> outReg == $past(busWData));
  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.rdEn |=> busRData == $past(busRData));
  p_reset_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (padOe == '0 && padOut == '0 && odReg == '0));
  p_od_no_high_r8: assert property (@(posedge clk) disable iff (!rstN)
    (padOut & odReg) == '0);
  p_in_follows_sync_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> inReg == $past(syncPipe[SYNC_STAGES-1]));
endmodule

// File: rtl/gpio32_ctrl.sv
module gpio32_ctrl
  import gpio32_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWData,
  input  logic              busWe,
  input  logic              busRe,
  output logic [DATA_W-1:0] busRData,
  input  logic [DATA_W-1:0] altOut1,
  input  logic [DATA_W-1:0] altOut2,
  input  logic [DATA_W-1:0] altOut3,
  input  logic [DATA_W-1:0] altOe1,
  input  logic [DATA_W-1:0] altOe2,
  input  logic [DATA_W-1:0] altOe3,
  output logic [DATA_W-1:0] padOut,
  output logic [DATA_W-1:0] padOe,
  input  logic [DATA_W-1:0] padIn
);
  gpioStrobe_t ctl;

  gpio32_regctl #(.AW(ADDR_W)) u_ctl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr),
    .busWe(busWe), .busRe(busRe), .ctl(ctl)
  );

  gpio32_datapath #(.PINS(DATA_W), .SYNC_STAGES(2)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .busWData(busWData), .busRData(busRData),
    .altOut1(altOut1), .altOut2(altOut2), .altOut3(altOut3),
    .altOe1(altOe1), .altOe2(altOe2), .altOe3(altOe3),
    .padOut(padOut), .padOe(padOe), .padIn(padIn)
  );
endmodule

// File: tb/gpio32_ctrl_test.sv
module gpio32_ctrl_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [6:0]  busAddr = '0;
  logic [31:0] busWData = '0;
  logic busWe = 1'b0, busRe = 1'b0;
  logic [31:0] busRData, padOut, padOe;
  logic [31:0] altOut1 = 32'hA5A5_0F0F, altOut2 = 32'h3C3C_F00F, altOut3 = 32'h6996_55AA;
  logic [31:0] altOe1  = 32'h0FF0_1234, altOe2  = 32'hF0F0_CCCC, altOe3  = 32'h5A5A_3333;
  logic [31:0] padIn = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio32_ctrl uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWData(busWData),
    .busWe(busWe), .busRe(busRe), .busRData(busRData),
    .altOut1(altOut1), .altOut2(altOut2), .altOut3(altOut3),
    .altOe1(altOe1), .altOe2(altOe2), .altOe3(altOe3),
    .padOut(padOut), .padOe(padOe), .padIn(padIn)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk); busAddr = a; busWData = d; busWe = 1'b1;
    @(negedge clk); busWe = 1'b0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; busRe = 1'b1;
    @(negedge clk); busRe = 1'b0; d = busRData;
  endtask

  function automatic logic [31:0] fieldWord(int pin, int code);
    return 32'(code) << (30 - 2 * (pin % 16));
  endfunction

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] r, expOut, expOe, altSel;
    logic [31:0] pats [4];
    logic [6:0] offs [7];
    pats[0] = 32'h1234_5678; pats[1] = 32'hFFFF_0000;
    pats[2] = 32'h8000_0001; pats[3] = 32'hC3A5_5A3C;
    offs = '{7'h00, 7'h04, 7'h08, 7'h0C, 7'h10, 7'h14, 7'h18};
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R3 reset state
    check("R3 padOut", padOut, 32'h0);
    check("R3 padOe", padOe, 32'h0);
    for (int i = 0; i < 7; i++) begin rd(offs[i], r); check("R3 reg", r, 32'h0); end

    // R2 readback of each writable register
    for (int i = 0; i < 7; i++) wr(offs[i], 32'h0101_0101 * (i + 1));
    for (int i = 0; i < 7; i++) begin rd(offs[i], r); check("R2 readback", r, 32'h0101_0101 * (i + 1)); end
    // R2 hold when busRe low
    @(negedge clk); busAddr = 7'h04;
    @(negedge clk); check("R2 hold", busRData, 32'h0707_0707);
    for (int i = 0; i < 7; i++) wr(offs[i], 32'h0);

    // R1/R4 drive enable and data, source 00
    for (int p = 0; p < 4; p++) begin
      wr(7'h00, pats[p]); wr(7'h04, ~pats[p] ^ 32'h0F0F_0F0F);
      check("R1 R4 padOut", padOut, pats[p]);
      check("R4 padOe", padOe, ~pats[p] ^ 32'h0F0F_0F0F);
    end
    // R1 single pin 0 is bit 31
    wr(7'h00, 32'h8000_0000); wr(7'h04, 32'h0000_0001);
    check("R1 pin0 msb", padOut, 32'h8000_0000);
    check("R1 pin31 lsb", padOe, 32'h0000_0001);

    // R5/R6 data source sweep
    wr(7'h00, 32'h1234_5678);
    for (int n = 0; n < 32; n++) begin
      for (int c = 0; c < 4; c++) begin
        wr(7'h08, n < 16 ? fieldWord(n, c) : 32'h0);
        wr(7'h0C, n < 16 ? 32'h0 : fieldWord(n, c));
        altSel = (c == 0) ? 32'h1234_5678 : (c == 1) ? altOut1 : (c == 2) ? altOut2 : altOut3;
        expOut = 32'h1234_5678;
        expOut[31-n] = altSel[31-n];
        check("R5 R6 data source", padOut, expOut);
      end
    end
    wr(7'h08, 32'h0); wr(7'h0C, 32'h0);

    // R5/R7 enable source sweep
    wr(7'h04, 32'h9696_3C3C);
    for (int n = 0; n < 32; n++) begin
      for (int c = 0; c < 4; c++) begin
        wr(7'h10, n < 16 ? fieldWord(n, c) : 32'h0);
        wr(7'h14, n < 16 ? 32'h0 : fieldWord(n, c));
        altSel = (c == 0) ? 32'h9696_3C3C : (c == 1) ? altOe1 : (c == 2) ? altOe2 : altOe3;
        expOe = 32'h9696_3C3C;
        expOe[31-n] = altSel[31-n];
        check("R5 R7 enable source", padOe, expOe);
      end
    end
    wr(7'h10, 32'h0); wr(7'h14, 32'h0);

    // R8 open drain with register sources
    for (int p = 0; p < 4; p++) begin
      wr(7'h00, pats[p]); wr(7'h04, 32'hFFFF_00FF); wr(7'h18, pats[(p+1)%4]);
      check("R8 od padOut", padOut, pats[p] & ~pats[(p+1)%4]);
      check("R8 od padOe", padOe, 32'hFFFF_00FF & ~(pats[(p+1)%4] & pats[p]));
    end
    // R8 open drain together with alternate sources on pin 5 and pin 20
    wr(7'h18, 32'h0400_0800);
    wr(7'h08, fieldWord(5, 3)); wr(7'h10, fieldWord(5, 2));
    wr(7'h0C, fieldWord(20, 1)); wr(7'h14, fieldWord(20, 3));
    expOut = pats[3]; expOut[26] = 1'b0; expOut[11] = 1'b0;
    expOe = 32'hFFFF_00FF;
    expOe[26] = altOe2[26] & ~altOut3[26];
    expOe[11] = altOe3[11] & ~altOut1[11];
    expOe[26-0] = expOe[26]; // pin 5
    check("R8 od alt padOut", padOut, expOut);
    check("R8 od alt padOe", padOe, expOe & ~(32'h0400_0800 & ~32'h0400_0800) );
    for (int i = 0; i < 7; i++) wr(offs[i], 32'h0);

    // R9 synchronizer depth
    @(negedge clk); padIn = 32'hDEAD_BEEF;
    @(negedge clk);
    rd(7'h1C, r); check("R9 not yet visible", r, 32'h0);
    rd(7'h1C, r); check("R9 visible", r, 32'hDEAD_BEEF);

    // R10 ignored writes
    wr(7'h00, 32'hCAFE_F00D);
    wr(7'h1C, 32'h1234_0000);
    rd(7'h1C, r); check("R10 input write ignored", r, 32'hDEAD_BEEF);
    for (int a = 8; a < 32; a++) begin
      wr(7'(a * 4), 32'hFFFF_FFFF);
      rd(7'(a * 4), r); check("R10 high offset reads 0", r, 32'h0);
    end
    rd(7'h00, r); check("R10 out unchanged", r, 32'hCAFE_F00D);
    check("R10 padOe unchanged", padOe, 32'h0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule